// File: doc/BRIEF.md
# Pipelined Steady-State Genetic Search Engine

This block runs a genetic search in hardware over a small population held in on-chip registers. One start pulse seeds a 32-bit maximal-length random source, fills every population slot with a random chromosome, and scores each slot. After that the engine evolves the population. Each cycle it draws two random slots as parents and passes them through four pipeline stages in a fixed order: select, single-point crossover, per-bit mutation, and a two-stage fitness evaluator. The evaluated child then reaches the write-back point. A new child leaves the pipeline every clock.

The population is updated in place. The child carries the slot number and the score of the weaker of its two parents. It overwrites that slot only when its own score is strictly higher, so the write-back point needs no second memory read. When two children in flight target the same slot, the later write wins. The built-in score is a weighted ones count. The engine tracks the best chromosome seen in the run and counts retired children. It raises `done` after a set number of children. Parent choice uses no fitness information.

The population depth must be a power of two, no larger than 4096. The chromosome width must lie between 2 and 32.

Top module: `ga_engine`

## Requirements
- R1: While reset is held and after it, `done` is 0, and `gen_count`, `best_fit` and `best_chrom` are all zero.
- R2: A `start` sampled high in the idle or finished state clears `gen_count`, `best_fit` and `best_chrom`. Call that clock edge edge 0. The engine then writes all POP_DEPTH slots, and `gen_count` stays 0 up to and including edge POP_DEPTH+7.
- R3: From edge POP_DEPTH+8 on, `gen_count` rises by exactly one at every edge until it reaches NUM_GEN.
- R4: `done` rises at edge POP_DEPTH+NUM_GEN+7 with `gen_count` equal to NUM_GEN. Both hold their values until the next accepted `start`.
- R5: `best_fit` always equals the weighted ones count of `best_chrom`. Bits below position CHROM_W/2 weigh 1 and the remaining bits weigh 2.
- R6: Within a run `best_fit` never decreases, so its final value is at least the best score present once filling ends.
- R7: A child replaces its weaker parent, or moves the best-so-far record, only when its score is strictly higher. A bit is flipped when its 8-bit random value is below `mut_thresh`, and with `xover_en` low the child is a copy of the first parent. So with `mut_thresh` = 0 and `xover_en` low, `best_fit` and `best_chrom` stay at their values from the end of filling.
- R8: Two runs with the same seed and settings give the same `best_chrom`, `best_fit` and `done` timing.
- R9: A seed of zero behaves exactly like a seed of 1, and the random source never holds the all-zero state.
- R10: A `start` pulse during filling, draining or evolution has no effect. The result and the `done` timing match a run without the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a new run (accepted only when idle or finished) |
| seed | input | 32 | Random source seed, loaded on an accepted start |
| mut_thresh | input | 8 | Per-bit mutation threshold |
| xover_en | input | 1 | Enables single-point crossover |
| best_chrom | output | CHROM_W | Best chromosome found in this run |
| best_fit | output | $clog2(2*CHROM_W+1) | Score of `best_chrom` |
| gen_count | output | $clog2(NUM_GEN+1) | Number of evolved children retired |
| done | output | 1 | Run finished |

## Verification
All timing is counted from edge 0, the edge where `start` is sampled. The last fill write lands at edge POP_DEPTH+2 and the first child retires at edge POP_DEPTH+8. `done` follows at edge POP_DEPTH+NUM_GEN+7. The bench counts edges from edge 0 and samples at the falling edge after each one. At every such sample it compares `gen_count` with the value that schedule predicts. It also checks that `best_fit` never falls. It takes the fill-time best after edge POP_DEPTH+3, and it compares the edge on which `done` is first seen against the predicted edge.

// File: rtl/ga_pkg.sv
`timescale 1ns/1ps
package ga_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FILL   = 3'd1,
    ST_DRAIN  = 3'd2,
    ST_EVOLVE = 3'd3,
    ST_FLUSH  = 3'd4,
    ST_DONE   = 3'd5
  } ga_state_e;

  // Fitness evaluator register stages; the drain wait is sized from it.
  localparam int FIT_STAGES = 2;

  // Galois mask of x^32 + x^22 + x^2 + x + 1 (maximal length)
  localparam logic [31:0] RNG_MASK = 32'h8020_0003;
  localparam logic [31:0] RNG_ZERO_SUB = 32'h0000_0001;

  // 8-bit random value for child bit i, taken from a rotated window of the state
  function automatic logic [7:0] bit_rand(input logic [31:0] s, input int unsigned i);
    logic [63:0] dbl;
    int unsigned sh;
    dbl = {s, s};
    sh  = (i * 7) % 32;
    return dbl[sh +: 8];
  endfunction

endpackage

// File: rtl/ga_rst_sync.sv
`timescale 1ns/1ps
module ga_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/ga_lfsr.sv
`timescale 1ns/1ps
module ga_lfsr
  import ga_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] seed,
  input  logic        adv,
  output logic [31:0] state
);
  logic [31:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (load) begin
      state_d = (seed == 32'd0) ? RNG_ZERO_SUB : seed;
    end else if (adv) begin
      state_d = {1'b0, state_q[31:1]} ^ (state_q[0] ? RNG_MASK : 32'd0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RNG_ZERO_SUB;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R9
  rng_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 32'd0);
endmodule

// File: rtl/ga_pop_mem.sv
`timescale 1ns/1ps
module ga_pop_mem #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  parameter int FW    = 6,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wchrom,
  input  logic [FW-1:0] wfit,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rchrom_a,
  output logic [FW-1:0] rfit_a,
  output logic [W-1:0]  rchrom_b,
  output logic [FW-1:0] rfit_b
);
  logic [W-1:0]  chrom_arr [DEPTH];
  logic [FW-1:0] fit_arr   [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      chrom_arr[waddr] <= wchrom;
      fit_arr[waddr]   <= wfit;
    end
  end

  assign rchrom_a = chrom_arr[raddr_a];
  assign rfit_a   = fit_arr[raddr_a];
  assign rchrom_b = chrom_arr[raddr_b];
  assign rfit_b   = fit_arr[raddr_b];
endmodule

// File: rtl/ga_fitness.sv
`timescale 1ns/1ps
module ga_fitness #(
  parameter int W  = 16,
  parameter int FW = 6,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [W-1:0]  in_chrom,
  input  logic [TW-1:0] in_tag,
  output logic          out_v,
  output logic [W-1:0]  out_chrom,
  output logic [FW-1:0] out_fit,
  output logic [TW-1:0] out_tag
);
  localparam int HALF = W / 2;

  logic [FW-1:0] lo_cnt, hi_cnt;
  logic          a_v;
  logic [FW-1:0] a_lo, a_hi;
  logic [W-1:0]  a_chrom;
  logic [TW-1:0] a_tag;

  // stage A: split ones count
  always_comb begin
    lo_cnt = '0;
    hi_cnt = '0;
    for (int i = 0; i < W; i++) begin
      if (i < HALF) lo_cnt = lo_cnt + FW'(in_chrom[i]);
      else          hi_cnt = hi_cnt + FW'(in_chrom[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_v   <= 1'b0;
      out_v <= 1'b0;
    end else begin
      a_v   <= in_v;
      out_v <= a_v;
    end
  end

  always_ff @(posedge clk) begin
    if (in_v) begin
      a_lo    <= lo_cnt;
      a_hi    <= hi_cnt;
      a_chrom <= in_chrom;
      a_tag   <= in_tag;
    end
  end

  // stage B: weighted sum
  always_ff @(posedge clk) begin
    if (a_v) begin
      out_fit   <= a_lo + (a_hi << 1);
      out_chrom <= a_chrom;
      out_tag   <= a_tag;
    end
  end
endmodule

// File: rtl/ga_engine.sv
`timescale 1ns/1ps
module ga_engine
  import ga_pkg::*;
#(
  parameter int CHROM_W   = 16,
  parameter int POP_DEPTH = 16,
  parameter int NUM_GEN   = 1024,
  localparam int AW = $clog2(POP_DEPTH),
  localparam int FW = $clog2(2 * CHROM_W + 1),
  localparam int GW = $clog2(NUM_GEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [31:0]        seed,
  input  logic [7:0]         mut_thresh,
  input  logic               xover_en,
  output logic [CHROM_W-1:0] best_chrom,
  output logic [FW-1:0]      best_fit,
  output logic [GW-1:0]      gen_count,
  output logic               done
);
  localparam int CW = $clog2(CHROM_W);
  localparam int TW = 1 + AW + FW;

  logic rst_n_s;
  ga_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  // ---------------- control ----------------
  ga_state_e      st_q, st_d;
  logic [AW-1:0]  cnt_q, cnt_d;
  logic [GW-1:0]  iss_q, iss_d;
  logic [GW-1:0]  gen_q, gen_d;
  logic           done_q, done_d;
  logic [CHROM_W-1:0] best_c_q, best_c_d;
  logic [FW-1:0]  best_f_q, best_f_d;

  logic start_ok, rng_adv, issue, fill_v;
  logic retire, accept, retire_last;
  logic [31:0] rng;

  // write-back side (fitness outputs)
  logic               fo_v;
  logic [CHROM_W-1:0] fo_chrom;
  logic [FW-1:0]      fo_fit;
  logic [TW-1:0]      fo_tag;
  logic               fo_force;
  logic [AW-1:0]      fo_addr;
  logic [FW-1:0]      fo_tfit;

  assign start_ok = start && (st_q == ST_IDLE || st_q == ST_DONE);
  assign rng_adv  = (st_q == ST_FILL) || (st_q == ST_DRAIN) ||
                    (st_q == ST_EVOLVE) || (st_q == ST_FLUSH);
  assign issue    = (st_q == ST_EVOLVE);
  assign fill_v   = (st_q == ST_FILL);

  assign {fo_force, fo_addr, fo_tfit} = fo_tag;
  assign retire      = fo_v && !fo_force;
  assign accept      = fo_v && (fo_force || (fo_fit > fo_tfit));
  assign retire_last = retire && (gen_q == GW'(NUM_GEN - 1));

  ga_lfsr u_rng (
    .clk(clk), .rst_n(rst_n_s), .load(start_ok), .seed(seed),
    .adv(rng_adv), .state(rng)
  );

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    iss_d = iss_q;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_ok) begin
          st_d  = ST_FILL;
          cnt_d = '0;
          iss_d = '0;
        end
      end
      ST_FILL: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == AW'(POP_DEPTH - 1)) begin
          st_d  = ST_DRAIN;
          cnt_d = '0;
        end
      end
      ST_DRAIN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == AW'(FIT_STAGES - 1)) st_d = ST_EVOLVE;
      end
      ST_EVOLVE: begin
        iss_d = iss_q + 1'b1;
        if (iss_q == GW'(NUM_GEN - 1)) st_d = ST_FLUSH;
      end
      ST_FLUSH: begin
        if (retire_last) st_d = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    gen_d    = gen_q;
    done_d   = done_q;
    best_c_d = best_c_q;
    best_f_d = best_f_q;
    if (start_ok) begin
      gen_d    = '0;
      done_d   = 1'b0;
      best_c_d = '0;
      best_f_d = '0;
    end else begin
      if (retire)      gen_d  = gen_q + 1'b1;
      if (retire_last) done_d = 1'b1;
      if (accept && (fo_fit > best_f_q)) begin
        best_c_d = fo_chrom;
        best_f_d = fo_fit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      iss_q    <= '0;
      gen_q    <= '0;
      done_q   <= 1'b0;
      best_c_q <= '0;
      best_f_q <= '0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      iss_q    <= iss_d;
      gen_q    <= gen_d;
      done_q   <= done_d;
      best_c_q <= best_c_d;
      best_f_q <= best_f_d;
    end
  end

  // ---------------- stage 0: random parent selection ----------------
  logic [AW-1:0]      sel_a, sel_b;
  logic [7:0]         cut_rand;
  logic [CHROM_W-1:0] par_a, par_b;
  logic [FW-1:0]      fit_a, fit_b;

  assign sel_a    = rng[AW-1:0];
  assign sel_b    = rng[2*AW-1:AW];
  assign cut_rand = rng[2*AW +: 8];

  ga_pop_mem #(.DEPTH(POP_DEPTH), .W(CHROM_W), .FW(FW)) u_pop (
    .clk(clk), .we(accept), .waddr(fo_addr), .wchrom(fo_chrom), .wfit(fo_fit),
    .raddr_a(sel_a), .raddr_b(sel_b),
    .rchrom_a(par_a), .rfit_a(fit_a), .rchrom_b(par_b), .rfit_b(fit_b)
  );

  // ---------------- stage 1 register ----------------
  logic               s1_v;
  logic [CHROM_W-1:0] s1_pa, s1_pb;
  logic [AW-1:0]      s1_addr;
  logic [FW-1:0]      s1_tfit;
  logic [CW-1:0]      s1_cut;

  always_ff @(posedge clk) begin
    if (issue) begin
      s1_pa   <= par_a;
      s1_pb   <= par_b;
      s1_addr <= (fit_a <= fit_b) ? sel_a : sel_b;
      s1_tfit <= (fit_a <= fit_b) ? fit_a : fit_b;
      s1_cut  <= CW'(1 + (int'(cut_rand) % (CHROM_W - 1)));
    end
  end

  // ---------------- stage 2: single-point crossover ----------------
  logic               s2_v;
  logic [CHROM_W-1:0] s2_child, low_mask;
  logic [AW-1:0]      s2_addr;
  logic [FW-1:0]      s2_tfit;

  assign low_mask = ~({CHROM_W{1'b1}} << s1_cut);

  always_ff @(posedge clk) begin
    if (s1_v) begin
      s2_child <= xover_en ? ((s1_pa & low_mask) | (s1_pb & ~low_mask)) : s1_pa;
      s2_addr  <= s1_addr;
      s2_tfit  <= s1_tfit;
    end
  end

  // ---------------- stage 3: per-bit mutation ----------------
  logic               s3_v;
  logic [CHROM_W-1:0] s3_child, flip;
  logic [AW-1:0]      s3_addr;
  logic [FW-1:0]      s3_tfit;

  for (genvar gi = 0; gi < CHROM_W; gi++) begin : g_mut
    assign flip[gi] = bit_rand(rng, gi) < mut_thresh;
  end

  always_ff @(posedge clk) begin
    if (s2_v) begin
      s3_child <= s2_child ^ flip;
      s3_addr  <= s2_addr;
      s3_tfit  <= s2_tfit;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
    end else begin
      s1_v <= issue;
      s2_v <= s1_v;
      s3_v <= s2_v;
    end
  end

  // ---------------- stages 4-5: fitness ----------------
  logic               fi_v;
  logic [CHROM_W-1:0] fi_chrom;
  logic [TW-1:0]      fi_tag;

  assign fi_v     = fill_v | s3_v;
  assign fi_chrom = fill_v ? rng[CHROM_W-1:0] : s3_child;
  assign fi_tag   = fill_v ? {1'b1, cnt_q, {FW{1'b0}}} : {1'b0, s3_addr, s3_tfit};

  ga_fitness #(.W(CHROM_W), .FW(FW), .TW(TW)) u_fit (
    .clk(clk), .rst_n(rst_n_s), .in_v(fi_v), .in_chrom(fi_chrom), .in_tag(fi_tag),
    .out_v(fo_v), .out_chrom(fo_chrom), .out_fit(fo_fit), .out_tag(fo_tag)
  );

  assign best_chrom = best_c_q;
  assign best_fit   = best_f_q;
  assign gen_count  = gen_q;
  assign done       = done_q;

  // ---------------- assertions ----------------
  // R2
  fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == ST_FILL) |-> (gen_q == '0));

  // R3
  gen_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (gen_q != $past(gen_q)) |-> ((gen_q == $past(gen_q) + 1'b1) || (gen_q == '0)));

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_q && !start) |=> (done_q && $stable(gen_q)));

  // R6
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$past(start_ok) |-> (best_f_q >= $past(best_f_q)));

  // R7
  mut_off_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(s2_v) && ($past(mut_thresh) == 8'd0)) |-> (s3_child == $past(s2_child)));

  // R10
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start && (st_q == ST_EVOLVE)) |=> (st_q != ST_FILL));
endmodule

// File: tb/tb_ga_engine.sv
`timescale 1ns/1ps
module tb_ga_engine;
  localparam int W  = 16;
  localparam int D  = 16;
  localparam int G  = 200;
  localparam int FW = $clog2(2 * W + 1);
  localparam int GW = $clog2(G + 1);
  localparam int DONE_EDGE = D + G + 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [31:0]   seed;
  logic [7:0]    mut_thresh;
  logic          xover_en;
  logic [W-1:0]  best_chrom;
  logic [FW-1:0] best_fit;
  logic [GW-1:0] gen_count;
  logic          done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  int r_done_edge, r_fill_best, r_best_f, r_sched_bad, r_mono_bad;
  logic [W-1:0] r_best_c;

  always #2 clk = ~clk;

  ga_engine #(.CHROM_W(W), .POP_DEPTH(D), .NUM_GEN(G)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
    .mut_thresh(mut_thresh), .xover_en(xover_en),
    .best_chrom(best_chrom), .best_fit(best_fit),
    .gen_count(gen_count), .done(done)
  );

  function automatic int score(input logic [W-1:0] c);
    int s = 0;
    for (int i = 0; i < W; i++) s += (i < W / 2) ? int'(c[i]) : 2 * int'(c[i]);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      finish_up();
    end
  end

  // One full run; edge 0 is the edge sampling start.
  task automatic run_ga(input logic [31:0] s, input logic [7:0] m,
                        input logic x, input int pulse_at);
    int k = 0;
    int prev = -1;
    int exp_gen;
    @(negedge clk);
    seed = s; mut_thresh = m; xover_en = x; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    r_done_edge = -1; r_sched_bad = 0; r_mono_bad = 0; r_fill_best = -1;
    while (k < DONE_EDGE + 40) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      exp_gen = (k <= D + 7) ? 0 : ((k - D - 7) > G ? G : (k - D - 7));
      if (int'(gen_count) != exp_gen) begin
        if (r_sched_bad == 0)
          $display("gen_count mismatch at edge %0d: %0d vs %0d", k, gen_count, exp_gen);
        r_sched_bad++;
      end
      if (prev >= 0 && int'(best_fit) < prev) r_mono_bad++;
      prev = int'(best_fit);
      if (k == D + 3) r_fill_best = int'(best_fit);
      start = (k == pulse_at);
      if (done) begin
        r_done_edge = k;
        break;
      end
    end
    start = 1'b0;
    r_best_f = int'(best_fit);
    r_best_c = best_chrom;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; seed = '0; mut_thresh = '0; xover_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    chk(gen_count == '0, "R1", "gen_count in reset", int'(gen_count), 0);
    chk(best_fit == '0, "R1", "best_fit in reset", int'(best_fit), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(best_chrom == '0 && done == 1'b0, "R1", "best_chrom after reset",
        int'(best_chrom), 0);
  endtask

  int base_f;
  logic [W-1:0] base_c;

  task automatic t_evolve();
    run_ga(32'h1234_ABCD, 8'd6, 1'b1, -1);
    chk(r_sched_bad == 0, "R2", "gen_count schedule mismatches", r_sched_bad, 0);
    chk(r_done_edge == DONE_EDGE, "R4", "done edge", r_done_edge, DONE_EDGE);
    chk(int'(gen_count) == G, "R3", "gen_count at done", int'(gen_count), G);
    chk(r_best_f == score(r_best_c), "R5", "best_fit vs score", r_best_f, score(r_best_c));
    chk(r_mono_bad == 0, "R6", "best_fit decreases", r_mono_bad, 0);
    chk(r_best_f >= r_fill_best, "R6", "final best vs fill best", r_best_f, r_fill_best);
    base_f = r_best_f;
    base_c = r_best_c;
    repeat (20) @(negedge clk);
    chk(done == 1'b1 && int'(gen_count) == G, "R4", "hold after done",
        int'(gen_count), G);
  endtask

  task automatic t_repeat();
    run_ga(32'h1234_ABCD, 8'd6, 1'b1, -1);
    chk(r_best_c == base_c, "R8", "repeat best_chrom", int'(r_best_c), int'(base_c));
    chk(r_best_f == base_f && r_done_edge == DONE_EDGE, "R8", "repeat best_fit",
        r_best_f, base_f);
  endtask

  task automatic t_zero_seed();
    logic [W-1:0] c1;
    int f1;
    run_ga(32'h0000_0001, 8'd10, 1'b1, -1);
    c1 = r_best_c; f1 = r_best_f;
    run_ga(32'h0000_0000, 8'd10, 1'b1, -1);
    chk(r_best_c == c1, "R9", "zero seed best_chrom", int'(r_best_c), int'(c1));
    chk(r_best_f == f1, "R9", "zero seed best_fit", r_best_f, f1);
  endtask

  task automatic t_frozen();
    run_ga(32'hC0FF_EE11, 8'd0, 1'b0, -1);
    chk(r_best_f == r_fill_best, "R7", "best moved without variation",
        r_best_f, r_fill_best);
    chk(r_best_f == score(r_best_c), "R5", "frozen best score", r_best_f, score(r_best_c));
    chk(r_done_edge == DONE_EDGE, "R4", "frozen done edge", r_done_edge, DONE_EDGE);
  endtask

  task automatic t_start_ignored();
    run_ga(32'h1234_ABCD, 8'd6, 1'b1, 5);
    chk(r_done_edge == DONE_EDGE, "R10", "done edge with fill start", r_done_edge, DONE_EDGE);
    run_ga(32'h1234_ABCD, 8'd6, 1'b1, 100);
    chk(r_done_edge == DONE_EDGE, "R10", "done edge with evolve start",
        r_done_edge, DONE_EDGE);
    chk(r_best_c == base_c && r_sched_bad == 0, "R10", "result with evolve start",
        int'(r_best_c), int'(base_c));
  endtask

  initial begin
    t_reset();
    t_evolve();
    t_repeat();
    t_zero_seed();
    t_frozen();
    t_start_ignored();
    finish_up();
  end
endmodule